// File: doc/BRIEF.md
# LCD Seven-Segment Digit Driver with Code Latch

This block turns a four-bit binary-coded-decimal value into the seven segment drive levels for one liquid-crystal digit. A load enable makes an internal register follow the input code. When the enable drops, the register keeps the last code it loaded, so the digit holds steady while the data bus moves on to other work.

A blank input turns the digit dark. Codes above nine also give a dark digit. A built-in clock divider makes a square wave with a 50 percent duty cycle. This wave is driven out as the common backplane level. Every segment output is XORed with the same wave, so a lit segment always sits at the opposite level to the backplane and a dark segment always sits at the same level. The display therefore never sees a DC bias.

Segments and backplane leave the block from registers loaded on the same clock edge. Any change on data, blank or phase reaches the pins together one clock later.

Top module: `lcd_digit_drive`

## Requirements
- R1: While `rst` is high, after a clock edge, `seg_o` is all zero and `bplane_o` is low. The stored code is cleared to 0, so with `load_en` low after reset the digit shows numeral 0.
- R2: For codes 0 to 9, the segment pattern is the matching numeral. `bcd_in[0]` is the least significant bit. In `seg_o`, bit 0 is segment a and bit 6 is segment g. With the backplane low the values are: 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F, 9=0x6F.
- R3: Codes 10 to 15 give a dark digit, with all segments at the backplane level.
- R4: With `blank` high, every segment sits at the backplane level, whatever code is stored.
- R5: While `load_en` is high, the displayed code follows `bcd_in`. While it is low, the code loaded last is kept and changes on `bcd_in` have no effect.
- R6: Every segment equals its pattern bit XOR `bplane_o`. With the backplane high, a dark digit drives all seven segments high.
- R7: `bplane_o` is a square wave whose level changes every `HALF_CYCLES` clock cycles.
- R8: A change on `bcd_in` (with `load_en` high) or on `blank` shows on `seg_o` after exactly one clock edge. The segments are aligned with the `bplane_o` value of that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bcd_in | input | 4 | BCD digit code |
| load_en | input | 1 | High: the register follows `bcd_in`; low: it holds |
| blank | input | 1 | High: dark digit |
| seg_o | output | 7 | Segment drive, bit 0 = a through bit 6 = g |
| bplane_o | output | 1 | Common backplane square wave |

## Verification
Faults show up at the pins quickly:
- A stuck or wrongly loaded code register shows a wrong numeral on the first clock edge after the load. If it fails to hold, the numeral changes one cycle after `bcd_in` moves while the enable is low.
- A divider that counts wrong shows a backplane level that lasts longer or shorter than `HALF_CYCLES`, and this is visible within one period.
- A phase path that lags or leads the backplane shows lit segments at the same level as the backplane for one cycle at each toggle.

// File: rtl/lcd7_pkg.sv
package lcd7_pkg;

    localparam int CODE_W = 4;
    localparam int SEG_N  = 7;

    typedef logic [CODE_W-1:0] bcd_t;
    typedef logic [SEG_N-1:0]  seg_t;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    typedef struct packed {
        bcd_t code;
        logic dark;
    } disp_req_t;

    // bit 0 = segment a ... bit 6 = segment g; codes above nine are dark
    function automatic seg_t seg_pattern(input bcd_t code);
        seg_t p;
        case (code)
            4'd0:    p = 7'b0111111;
            4'd1:    p = 7'b0000110;
            4'd2:    p = 7'b1011011;
            4'd3:    p = 7'b1001111;
            4'd4:    p = 7'b1100110;
            4'd5:    p = 7'b1101101;
            4'd6:    p = 7'b1111101;
            4'd7:    p = 7'b0000111;
            4'd8:    p = 7'b1111111;
            4'd9:    p = 7'b1101111;
            default: p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/lcd_phase_div.sv
module lcd_phase_div #(
    parameter int HALF_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    output lcd7_pkg::phase_e phase_o
);
    import lcd7_pkg::*;

    localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    phase_e        phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            phase_q <= PH_LOW;
        end else if (cnt_q == LAST) begin
            cnt_q   <= '0;
            phase_q <= (phase_q == PH_LOW) ? PH_HIGH : PH_LOW;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign phase_o = phase_q;

    p_phase_steady_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != LAST) |=> $stable(phase_q));
    p_phase_flip_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == LAST) |=> (phase_q != $past(phase_q)));

endmodule

// File: rtl/bcd_hold_reg.sv
module bcd_hold_reg (
    input  logic           clk,
    input  logic           rst,
    input  lcd7_pkg::bcd_t din,
    input  logic           load_en,
    output lcd7_pkg::bcd_t view_o
);
    import lcd7_pkg::*;

    bcd_t held_q;

    always_ff @(posedge clk) begin
        if (rst)
            held_q <= '0;
        else if (load_en)
            held_q <= din;
    end

    // with the enable high the fresh code goes straight to the output stage
    assign view_o = load_en ? din : held_q;

    p_hold_keeps_r5: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(held_q));
    p_hold_loads_r5: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (held_q == $past(din)));

endmodule

// File: rtl/seg_drive_stage.sv
module seg_drive_stage (
    input  logic                clk,
    input  logic                rst,
    input  lcd7_pkg::disp_req_t req,
    input  lcd7_pkg::phase_e    phase,
    output lcd7_pkg::seg_t      seg_q,
    output logic                bp_q
);
    import lcd7_pkg::*;

    seg_t pat;

    always_comb begin
        pat = req.dark ? '0 : seg_pattern(req.code);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q <= '0;
            bp_q  <= 1'b0;
        end else begin
            seg_q <= pat ^ {SEG_N{phase == PH_HIGH}};
            bp_q  <= (phase == PH_HIGH);
        end
    end

    p_dark_matches_bp_r4: assert property (@(posedge clk) disable iff (rst)
        req.dark |=> (seg_q == {SEG_N{bp_q}}));
    p_bad_code_dark_r3: assert property (@(posedge clk) disable iff (rst)
        (req.code > 4'd9) |=> (seg_q == {SEG_N{bp_q}}));
    p_eight_all_lit_r6: assert property (@(posedge clk) disable iff (rst)
        (!req.dark && req.code == 4'd8) |=> (seg_q == {SEG_N{!bp_q}}));

endmodule

// File: rtl/lcd_digit_drive.sv
module lcd_digit_drive #(
    parameter int HALF_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] bcd_in,
    input  logic       load_en,
    input  logic       blank,
    output logic [6:0] seg_o,
    output logic       bplane_o
);
    import lcd7_pkg::*;

    bcd_t      code_view;
    phase_e    phase;
    disp_req_t req;
    seg_t      seg_q;

    lcd_phase_div #(.HALF_CYCLES(HALF_CYCLES)) u_div (
        .clk     (clk),
        .rst     (rst),
        .phase_o (phase)
    );

    bcd_hold_reg u_hold (
        .clk     (clk),
        .rst     (rst),
        .din     (bcd_in),
        .load_en (load_en),
        .view_o  (code_view)
    );

    always_comb begin
        req.code = code_view;
        req.dark = blank;
    end

    seg_drive_stage u_drive (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .phase (phase),
        .seg_q (seg_q),
        .bp_q  (bplane_o)
    );

    assign seg_o = seg_q;

    p_reset_dark_r1: assert property (@(posedge clk)
        $past(rst) |-> (seg_o == '0 && !bplane_o));

endmodule

// File: tb/lcd_digit_drive_bench.sv
module lcd_digit_drive_bench;

    localparam int PERIOD = 10;
    localparam int H      = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bcd_in = '0;
    logic       load_en = 1'b0;
    logic       blank = 1'b0;
    logic [6:0] seg_o;
    logic       bplane_o;

    int vectors = 0;
    int errors  = 0;

    always #(PERIOD/2) clk = ~clk;

    lcd_digit_drive #(.HALF_CYCLES(H)) u_lcd_digit_drive (
        .clk      (clk),
        .rst      (rst),
        .bcd_in   (bcd_in),
        .load_en  (load_en),
        .blank    (blank),
        .seg_o    (seg_o),
        .bplane_o (bplane_o)
    );

    function automatic logic [6:0] ref_pat(input int code, input bit dk);
        logic [6:0] p;
        if (dk) return 7'h00;
        case (code)
            0: p = 7'h3F; 1: p = 7'h06; 2: p = 7'h5B; 3: p = 7'h4F;
            4: p = 7'h66; 5: p = 7'h6D; 6: p = 7'h7D; 7: p = 7'h07;
            8: p = 7'h7F; 9: p = 7'h6F;
            default: p = 7'h00;
        endcase
        return p;
    endfunction

    task automatic check_seg(input string req, input logic [6:0] pat);
        logic [6:0] exp;
        exp = pat ^ {7{bplane_o}};
        vectors++;
        if (seg_o !== exp) begin
            errors++;
            $display("FAIL %s: seg_o=%h expected %h (bp=%b)", req, seg_o, exp, bplane_o);
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    endtask

    // R7: backplane run length monitor
    bit seen = 0;
    int run  = 0;
    logic prev_bp = 1'b0;
    always @(negedge clk) begin
        if (rst) begin
            seen = 0; run = 0; prev_bp = bplane_o;
        end else if (bplane_o !== prev_bp) begin
            if (seen) begin
                vectors++;
                if (run != H) begin
                    errors++;
                    $display("FAIL R7: backplane run %0d expected %0d", run, H);
                end
            end
            seen = 1; run = 1; prev_bp = bplane_o;
        end else begin
            run++;
        end
    end

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        vectors++;
        if (seg_o !== 7'h00 || bplane_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: seg_o=%h bp=%b expected 00 0", seg_o, bplane_o);
        end
        rst = 1'b0;
        @(negedge clk);
        check_seg("R1 cleared code shows 0", ref_pat(0, 0));

        // R2 R3 R4 R6 R8: every code, dark on and off, across both phases
        for (int b = 0; b < 2; b++) begin
            for (int c = 0; c < 16; c++) begin
                load_en = 1'b1;
                bcd_in  = 4'(c);
                blank   = b[0];
                for (int k = 0; k < 2*H + 1; k++) begin
                    @(negedge clk);
                    if (b == 1)
                        check_seg("R4 blank dark", ref_pat(c, 1));
                    else if (c > 9)
                        check_seg("R3 code above nine dark", ref_pat(c, 0));
                    else if (k == 0)
                        check_seg("R8 one-cycle latency", ref_pat(c, 0));
                    else
                        check_seg("R2 R6 numeral xor backplane", ref_pat(c, 0));
                end
            end
        end

        // R5: hold while the enable is low
        blank = 1'b0; load_en = 1'b1; bcd_in = 4'd5;
        @(negedge clk);
        check_seg("R5 load 5", ref_pat(5, 0));
        load_en = 1'b0; bcd_in = 4'd8;
        for (int k = 0; k < 2*H; k++) begin
            @(negedge clk);
            check_seg("R5 hold 5 ignores input 8", ref_pat(5, 0));
            bcd_in = 4'(k + 1);
        end
        blank = 1'b1;
        @(negedge clk);
        check_seg("R4 blank over held code", ref_pat(5, 1));
        blank = 1'b0;
        @(negedge clk);
        check_seg("R5 held code back after blank", ref_pat(5, 0));
        load_en = 1'b1; bcd_in = 4'd9;
        @(negedge clk);
        check_seg("R5 follow again 9", ref_pat(9, 0));
        load_en = 1'b0; bcd_in = 4'd1;
        repeat (2*H) begin
            @(negedge clk);
            check_seg("R5 hold 9", ref_pat(9, 0));
        end

        summary();
        $finish;
    end

endmodule